// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out the three configuration instructions of a vector extension: the one with the vector type as an 11-bit immediate, the one with both the length and the type as immediates, and the one with the type taken from a register. Each instruction gives a requested application vector length (AVL) and a requested vector type. The unit checks whether the type is legal and works out the largest element count (VLMAX) for the chosen element width and register grouping. It then writes the architectural vector-length and vector-type registers and returns the granted length to the scalar destination register.

VLMAX is formed with shifts only. The elements per register are `VLEN/8` shifted right by the width code. Grouping of 2, 4 or 8 shifts this count left, and the fractional groupings 1/2, 1/4 and 1/8 shift it right. No fractional arithmetic is needed. Every illegal type collapses the state to a type word in which only the illegal flag is set, with a length of zero. The register size in bytes is given as a constant output.

Top module: `vcfg_unit`

## Requirements
- R1: The length (`vl_o`) and type (`vtype_o`) change only on a cycle with `valid_i` high. Reset gives `vl_o`=0 and `vtype_o`=32'h8000_0000.
- R2: Type word fields are: `[2:0]` group code, `[5:3]` width code, bit 6 tail flag, bit 7 mask flag, bit 31 illegal flag. Width codes 0/1/2 mean 8/16/32-bit elements. Group codes 0/1/2/3 mean 1/2/4/8 registers, and 5/6/7 mean 1/8, 1/4 and 1/2. VLMAX = group × 128 / width.
- R3: An illegal request sets `vtype_o` to 32'h8000_0000 and `vl_o` to 0, and returns 0 to the destination.
- R4: A request is illegal when any of these holds: the width code is above 2, the group code is 4, any of bits `[31:8]` is set, or a fractional group makes VLMAX zero.
- R5: For a legal request with a non-zero source index, or for the immediate form, `vl` = AVL when AVL ≤ VLMAX, and `vl` = VLMAX otherwise. AVL is compared as an unsigned 32-bit value.
- R6: In the register-length forms, a source index of 0 with a non-zero destination index requests the maximum: `vl` = VLMAX.
- R7: In the register-length forms, source and destination indices both 0 with a legal type keep `vl` unchanged and still update the type.
- R8: With `kind_i`=01, AVL is the 5-bit `uimm_i` and the type is `zimm_i[9:0]`; `zimm_i[10]` is ignored. With `kind_i`=00, the type is all 11 bits of `zimm_i`.
- R9: With `kind_i`=10 or 11, the type is the full 32-bit `rs2_val_i`.
- R10: One cycle after each accepted request, `done_o` pulses for one cycle. `rd_we_o` is high with it exactly when `rd_idx_i` was non-zero, and `rd_wdata_o` holds the new `vl`.
- R11: `vlenb_o` is the constant VLEN/8 (16 by default).
- R12: On a legal request, the tail and mask flag bits are stored and shown unchanged in `vtype_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe, one per instruction |
| kind_i | input | 2 | 00 immediate type, 01 immediate length and type, 10/11 register type |
| rs1_idx_i | input | 5 | Source register index |
| rd_idx_i | input | 5 | Destination register index |
| rs1_val_i | input | 32 | Source register value (AVL) |
| uimm_i | input | 5 | Immediate AVL |
| zimm_i | input | 11 | Immediate type |
| rs2_val_i | input | 32 | Register type value |
| done_o | output | 1 | Completion pulse |
| rd_we_o | output | 1 | Destination write enable |
| rd_wdata_o | output | 32 | Granted length for the destination |
| vl_o | output | 32 | Current vector length |
| vtype_o | output | 32 | Current vector type |
| vlenb_o | output | 32 | Register size in bytes |

## Verification
Some properties are checked on every cycle by the assertions. The collapsed illegal state always pairs a bare illegal flag with zero length. Idle cycles leave both registers untouched. Every request yields exactly one completion pulse, and the write enable never appears without it. A granted length never exceeds the VLMAX of its request. A max request lands exactly on VLMAX, and the keep form holds the length.

Other behaviours show only in the bench's scenarios: the exact VLMAX for each width and group pair, the fractional cases that just fail or just pass, and each illegal cause. The scenarios also cover the ignored immediate bit, the two register-type kinds, and the preserved tail and mask flags. Each of these is compared against a model written from the requirements.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  localparam int unsigned XLEN = 32;

  typedef enum logic [1:0] {
    CFG_VLI    = 2'b00,
    CFG_IVLI   = 2'b01,
    CFG_VL     = 2'b10,
    CFG_VL_ALT = 2'b11
  } cfg_kind_e;

  typedef struct packed {
    logic        ill;
    logic [22:0] rsvd;
    logic        ma;
    logic        ta;
    logic [2:0]  sew;
    logic [2:0]  lmul;
  } vtype_t;

  localparam logic [2:0] LMUL_RSVD = 3'b100;
  localparam vtype_t     VTYPE_ILL = '{ill: 1'b1, default: '0};

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
  import vcfg_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 32,
  parameter int unsigned VL_W = $clog2(VLEN) + 1
) (
  input  vtype_t          req_i,
  output logic            legal_o,
  output logic [VL_W-1:0] vl_max_o
);

  localparam logic [2:0]      SEW_MAX    = 3'($clog2(ELEN / 8));
  localparam logic [VL_W-1:0] E8_PER_REG = VL_W'(VLEN / 8);

  logic            sew_ok, lmul_ok, rsvd_ok;
  logic [VL_W-1:0] per_reg;
  logic [2:0]      frac_sh;

  assign sew_ok  = req_i.sew <= SEW_MAX;
  assign lmul_ok = req_i.lmul != LMUL_RSVD;
  assign rsvd_ok = !req_i.ill && (req_i.rsvd == '0);

  // elements per register = (VLEN/8) >> sew
  assign per_reg = E8_PER_REG >> req_i.sew;
  // codes 5,6,7 -> right shift 3,2,1
  assign frac_sh = 3'd0 - req_i.lmul;

  always_comb begin
    if (req_i.lmul[2]) vl_max_o = per_reg >> frac_sh;
    else               vl_max_o = per_reg << req_i.lmul[1:0];
  end

  assign legal_o = sew_ok && lmul_ok && rsvd_ok && (vl_max_o != '0);

endmodule

// File: rtl/vcfg_avl.sv
module vcfg_avl
  import vcfg_pkg::*;
#(
  parameter int unsigned VL_W = 8
) (
  input  cfg_kind_e       kind_i,
  input  logic [4:0]      rs1_idx_i,
  input  logic [4:0]      rd_idx_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [4:0]      uimm_i,
  input  logic            legal_i,
  input  logic [VL_W-1:0] vl_max_i,
  input  logic [VL_W-1:0] vl_cur_i,
  output logic [VL_W-1:0] vl_new_o,
  output logic            keep_o,
  output logic            use_max_o
);

  logic            avl_imm;
  logic [XLEN-1:0] avl, vl_max_ext;
  logic [VL_W-1:0] clamped;

  assign avl_imm    = kind_i == CFG_IVLI;
  assign use_max_o  = !avl_imm && (rs1_idx_i == '0) && (rd_idx_i != '0);
  assign keep_o     = !avl_imm && (rs1_idx_i == '0) && (rd_idx_i == '0);
  assign avl        = avl_imm ? XLEN'(uimm_i) : rs1_val_i;
  assign vl_max_ext = XLEN'(vl_max_i);
  assign clamped    = (avl > vl_max_ext) ? vl_max_i : avl[VL_W-1:0];

  always_comb begin
    if (!legal_i)       vl_new_o = '0;
    else if (keep_o)    vl_new_o = vl_cur_i;
    else if (use_max_o) vl_new_o = vl_max_i;
    else                vl_new_o = clamped;
  end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned ELEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      kind_i,
  input  logic [4:0]      rs1_idx_i,
  input  logic [4:0]      rd_idx_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [4:0]      uimm_i,
  input  logic [10:0]     zimm_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            done_o,
  output logic            rd_we_o,
  output logic [XLEN-1:0] rd_wdata_o,
  output logic [XLEN-1:0] vl_o,
  output logic [XLEN-1:0] vtype_o,
  output logic [XLEN-1:0] vlenb_o
);

  localparam int unsigned VL_W = $clog2(VLEN) + 1;

  cfg_kind_e       kind;
  vtype_t          req_vtype;
  logic            cfg_legal, keep, use_max;
  logic [VL_W-1:0] vl_max, vl_new;
  logic [VL_W-1:0] vl_q;
  vtype_t          vtype_q;
  logic            done_q, rd_we_q;

  assign kind = cfg_kind_e'(kind_i);

  always_comb begin
    unique case (kind)
      CFG_VLI:  req_vtype = vtype_t'({21'b0, zimm_i});
      CFG_IVLI: req_vtype = vtype_t'({22'b0, zimm_i[9:0]});
      default:  req_vtype = vtype_t'(rs2_val_i);
    endcase
  end

  vcfg_decode #(.VLEN(VLEN), .ELEN(ELEN), .VL_W(VL_W)) u_decode (
    .req_i   (req_vtype),
    .legal_o (cfg_legal),
    .vl_max_o(vl_max)
  );

  vcfg_avl #(.VL_W(VL_W)) u_avl (
    .kind_i   (kind),
    .rs1_idx_i(rs1_idx_i),
    .rd_idx_i (rd_idx_i),
    .rs1_val_i(rs1_val_i),
    .uimm_i   (uimm_i),
    .legal_i  (cfg_legal),
    .vl_max_i (vl_max),
    .vl_cur_i (vl_q),
    .vl_new_o (vl_new),
    .keep_o   (keep),
    .use_max_o(use_max)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q    <= '0;
      vtype_q <= VTYPE_ILL;
      done_q  <= 1'b0;
      rd_we_q <= 1'b0;
    end else begin
      done_q  <= valid_i;
      rd_we_q <= valid_i && (rd_idx_i != '0);
      if (valid_i) begin
        vl_q    <= vl_new;
        vtype_q <= cfg_legal ? req_vtype : VTYPE_ILL;
      end
    end
  end

  assign done_o     = done_q;
  assign rd_we_o    = rd_we_q;
  assign vl_o       = XLEN'(vl_q);
  assign rd_wdata_o = XLEN'(vl_q);
  assign vtype_o    = vtype_q;
  assign vlenb_o    = XLEN'(VLEN / 8);

  a_r3_ill_collapse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vtype_q.ill |-> (vtype_q[XLEN-2:0] == '0) && (vl_q == '0));

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(vl_q) && $stable(vtype_q));

  a_r10_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);

  a_r10_we_in_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> done_o);

  a_r5_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_legal && !keep) |=> (vl_q <= $past(vl_max)));

  a_r6_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_legal && use_max) |=> (vl_q == $past(vl_max)));

  a_r7_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_legal && keep) |=> $stable(vl_q));

endmodule

// File: tb/vcfg_unit_test.sv
module vcfg_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  kind = '0;
  logic [4:0]  rs1_idx = '0, rd_idx = '0, uimm = '0;
  logic [31:0] rs1_val = '0, rs2_val = '0;
  logic [10:0] zimm = '0;
  logic        done, rd_we;
  logic [31:0] rd_wdata, vl, vtype, vlenb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] vl;
    logic [31:0] vt;
    logic        we;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] model_vl = '0;
  logic [31:0] model_vt = 32'h8000_0000;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vcfg_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .kind_i(kind),
    .rs1_idx_i(rs1_idx), .rd_idx_i(rd_idx), .rs1_val_i(rs1_val),
    .uimm_i(uimm), .zimm_i(zimm), .rs2_val_i(rs2_val),
    .done_o(done), .rd_we_o(rd_we), .rd_wdata_o(rd_wdata),
    .vl_o(vl), .vtype_o(vtype), .vlenb_o(vlenb)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_vlmax(input logic [31:0] vt);
    int num, den, sew, r;
    if (vt[31:8] != 0) return -1;
    if (vt[5:3] > 3'd2) return -1;
    case (vt[2:0])
      3'd0: begin num = 1; den = 1; end
      3'd1: begin num = 2; den = 1; end
      3'd2: begin num = 4; den = 1; end
      3'd3: begin num = 8; den = 1; end
      3'd5: begin num = 1; den = 8; end
      3'd6: begin num = 1; den = 4; end
      3'd7: begin num = 1; den = 2; end
      default: return -1;
    endcase
    sew = 8 << vt[5:3];
    r = (128 * num) / (sew * den);
    return (r == 0) ? -1 : r;
  endfunction

  function automatic logic [10:0] vt(input int sew, input int lm, input bit ta, input bit ma);
    return {3'b0, ma, ta, 3'(sew), 3'(lm)};
  endfunction

  task automatic issue(input logic [1:0] k, input logic [4:0] rs1, input logic [4:0] rd,
                       input logic [31:0] rs1v, input logic [4:0] ui, input logic [10:0] zi,
                       input logic [31:0] rs2v, input string tag);
    logic [31:0] req, avl;
    int lim;
    exp_t e;
    if (k == 2'b00)      req = {21'b0, zi};
    else if (k == 2'b01) req = {22'b0, zi[9:0]};
    else                 req = rs2v;
    lim = exp_vlmax(req);
    if (lim < 0) begin
      model_vt = 32'h8000_0000;
      model_vl = 0;
    end else begin
      model_vt = req;
      avl = (k == 2'b01) ? {27'b0, ui} : rs1v;
      if (k != 2'b01 && rs1 == 0) begin
        if (rd != 0) model_vl = lim;
      end else begin
        model_vl = (avl > 32'(lim)) ? 32'(lim) : avl;
      end
    end
    e.vl = model_vl; e.vt = model_vt; e.we = (rd != 0); e.tag = tag;
    @(negedge clk);
    sb.push_back(e);
    valid = 1'b1; kind = k; rs1_idx = rs1; rd_idx = rd;
    rs1_val = rs1v; uimm = ui; zimm = zi; rs2_val = rs2v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
      rs1_val = 32'hA5A5_0000 + 32'(i);
      rs2_val = 32'h0000_0003;
      zimm = 11'h7FF;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk("R10 unexpected done", 32'(done), 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({e.tag, " vl"}, vl, e.vl);
          chk({e.tag, " vtype"}, vtype, e.vt);
          chk({e.tag, " R10 rd_wdata"}, rd_wdata, e.vl);
          chk({e.tag, " R10 rd_we"}, 32'(rd_we), 32'(e.we));
        end
      end else begin
        chk("R10 rd_we without done", 32'(rd_we), 32'd0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: act=%0d exp=<20000 cycles", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset vl", vl, 32'd0);
    chk("R1 reset vtype", vtype, 32'h8000_0000);
    chk("R11 vlenb", vlenb, 32'd16);
    chk("R10 reset done", 32'(done), 32'd0);
    rst_n = 1'b1;

    issue(2'b00, 5'd1, 5'd2, 32'd1000, 5'd0, vt(0, 3, 0, 0), 0, "R2 R5 sew8 lmul8");
    issue(2'b00, 5'd1, 5'd2, 32'd10, 5'd0, vt(2, 0, 0, 0), 0, "R2 R5 sew32 lmul1 clamp");
    issue(2'b00, 5'd1, 5'd2, 32'd3, 5'd0, vt(2, 0, 0, 0), 0, "R5 avl below");
    issue(2'b00, 5'd1, 5'd2, 32'd4, 5'd0, vt(2, 0, 0, 0), 0, "R5 avl equal");
    issue(2'b00, 5'd1, 5'd2, 32'hFFFF_FFFF, 5'd0, vt(1, 2, 0, 0), 0, "R5 avl all ones");
    issue(2'b00, 5'd1, 5'd2, 32'd100, 5'd0, vt(0, 5, 0, 0), 0, "R2 frac 1/8 sew8");
    issue(2'b00, 5'd1, 5'd2, 32'd100, 5'd0, vt(1, 6, 0, 0), 0, "R2 frac 1/4 sew16");
    issue(2'b00, 5'd1, 5'd2, 32'd100, 5'd0, vt(2, 7, 0, 0), 0, "R2 frac 1/2 sew32");
    issue(2'b00, 5'd1, 5'd2, 32'd100, 5'd0, vt(1, 5, 0, 0), 0, "R4 frac 1/8 sew16 legal");
    issue(2'b00, 5'd1, 5'd2, 32'd100, 5'd0, vt(2, 5, 0, 0), 0, "R3 R4 frac 1/8 sew32 illegal");
    issue(2'b00, 5'd1, 5'd2, 32'd7, 5'd0, vt(0, 0, 1, 0), 0, "R12 ta set");
    issue(2'b00, 5'd1, 5'd2, 32'd7, 5'd0, vt(3, 0, 0, 0), 0, "R3 R4 sew64 illegal");
    issue(2'b00, 5'd1, 5'd2, 32'd7, 5'd0, vt(0, 4, 0, 0), 0, "R3 R4 lmul code4 illegal");
    issue(2'b00, 5'd1, 5'd2, 32'd7, 5'd0, 11'h100 | vt(0, 0, 0, 0), 0, "R4 zimm bit8 illegal");
    issue(2'b00, 5'd0, 5'd5, 32'd3, 5'd0, vt(1, 1, 0, 1), 0, "R6 R12 max request");
    issue(2'b00, 5'd0, 5'd0, 32'd3, 5'd0, vt(1, 0, 1, 1), 0, "R7 keep vl");
    issue(2'b00, 5'd4, 5'd0, 32'd5, 5'd0, vt(0, 0, 0, 0), 0, "R10 rd x0 no write");
    issue(2'b01, 5'd0, 5'd3, 32'd99, 5'd31, vt(0, 0, 0, 0), 0, "R8 imm avl clamp");
    issue(2'b01, 5'd0, 5'd3, 32'd99, 5'd7, vt(0, 1, 1, 1), 0, "R8 R12 imm avl 7");
    issue(2'b01, 5'd0, 5'd3, 32'd99, 5'd9, 11'h400 | vt(1, 0, 0, 0), 0, "R8 zimm bit10 ignored");
    issue(2'b00, 5'd1, 5'd3, 32'd9, 5'd0, 11'h400 | vt(1, 0, 0, 0), 0, "R8 R4 zimm bit10 illegal");
    issue(2'b10, 5'd3, 5'd6, 32'd9, 5'd0, 0, {24'b0, vt(2, 2, 0, 0)}, "R9 reg type");
    issue(2'b11, 5'd3, 5'd6, 32'd50, 5'd0, 0, {24'b0, vt(0, 7, 1, 0)}, "R9 kind11 reg type");
    issue(2'b10, 5'd3, 5'd6, 32'd9, 5'd0, 0, 32'h8000_0000 | vt(0, 0, 0, 0), "R9 R4 ill bit set");
    issue(2'b10, 5'd3, 5'd6, 32'd9, 5'd0, 0, 32'h0001_0000 | vt(0, 0, 0, 0), "R9 R4 high bit set");
    issue(2'b10, 5'd0, 5'd6, 32'd9, 5'd0, 0, {24'b0, vt(2, 3, 0, 0)}, "R6 R9 reg max");
    idle(1);
    idle(6);
    chk("R1 idle vl", vl, model_vl);
    chk("R1 idle vtype", vtype, model_vt);
    issue(2'b00, 5'd0, 5'd0, 32'd0, 5'd0, vt(2, 0, 0, 0), 0, "R7 keep after idle");
    idle(4);
    chk("R10 scoreboard drained", 32'(sb.size()), 32'd0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule